// File: doc/BRIEF.md
# Direct-Mapped Cache with Exclusive Victim Buffer

This block is a word-addressed, direct-mapped cache, extended with a small fully associative victim buffer. Every block that the main array displaces lands in the victim buffer, so the two structures together behave like a cache of higher associativity for addresses that contend for one index. Each request is looked up in both structures at once. A block lives in exactly one of them. A hit in the victim buffer exchanges that block with the block currently at the target index of the main array.

Stores use write-through without allocation. The cache therefore never holds data that memory lacks, and a block that falls out of the victim buffer is simply discarded. The lower-memory port carries single-word writes and block-fill reads, each under a valid/ready handshake. Fill data comes back as one full block in a single response beat. A requester presents a request and holds it until `cpu_ready` is high.

Top module: `cvb_cache`

## Requirements
- R1: After reset, no entry is valid in either structure and the victim buffer is empty. With no request present, `cpu_ready` and `mem_req_valid` are low, and the first read to any address misses.
- R2: A read that hits the main array completes in the cycle it is presented. It returns `cpu_hit`=1 and the addressed word, and issues no memory request.
- R3: A read that misses both structures issues one memory read (`mem_req_we`=0) at the block-aligned word address, with the low offset bits at zero. The response carries word k of the block in bits [k*DATA_W +: DATA_W]. The request then completes with `cpu_hit`=0 and the addressed word.
- R4: When a fill replaces a valid main block, that block enters the victim buffer. A later read of it hits (`cpu_hit`=1) without any memory request.
- R5: A victim-buffer read hit takes one swap cycle. `cpu_ready` stays low for the first two cycles of the request and rises in the third, with `cpu_hit`=1.
- R6: A block is held in the main array or in the victim buffer, never both. After a swap, the main block that was displaced is found again through the victim buffer.
- R7: The victim buffer is ordered by insertion age. A hit removes that entry, and the block that the hit displaces is appended as the youngest. When the buffer is full and one more block enters, the oldest entry is dropped, and a later read of the dropped block misses.
- R8: A write that hits the main array updates the cached word and issues one memory write with the word address and data. It completes with `cpu_hit`=1 in the cycle the write is accepted, which is the second cycle of the request when memory is ready.
- R9: A write that misses both structures issues one memory write and completes with `cpu_hit`=0 in its second cycle. It allocates nothing, so a later read of that address misses.
- R10: A write whose block is in the victim buffer first swaps that block into the main array and then writes through. It completes in the fourth cycle with `cpu_hit`=1.
- R11: The index is block-address bits [IDX_W-1:0] and the tag is the block-address bits above them. Blocks with different indices coexist in the main array. Blocks with the same index displace one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completed request was found in the cache without a fill |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = word write, 0 = block fill read |
| mem_req_addr | output | ADDR_W | Word address (block-aligned for fills) |
| mem_req_wdata | output | DATA_W | Word to write |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_block | input | WORDS*DATA_W | Fill block, word 0 in the low bits |

## Verification
Two victim-buffer operations can land in one clock edge. In a swap, an entry is removed and the displaced main block is appended. When a fill meets a full buffer, the oldest entry is dropped while the displaced block is appended. The bench provokes both by sending runs of addresses that share one index. It first fills the buffer, then hits its middle entries, then evicts again. A behavioural queue tracks the expected order, and after each request it predicts hit or miss, latency and memory traffic. A following long pseudo-random run mixes reads and writes over a few indices, so that swaps, drops and write-through stores alternate in every order.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  typedef enum logic [2:0] {
    ST_LOOK  = 3'd0,
    ST_SWAP  = 3'd1,
    ST_FREQ  = 3'd2,
    ST_FWAIT = 3'd3,
    ST_WRITE = 3'd4
  } cvb_state_e;
endpackage

// File: rtl/cvb_main_array.sv
module cvb_main_array #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 7,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << IDX_W,
  localparam int BLK_W = (1 << OFF_W) * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag_out,
  output logic [BLK_W-1:0]  lk_block,
  input  logic              ld_en,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [BLK_W-1:0]  ld_block,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [BLK_W-1:0] dat_q [SETS];

  assign lk_valid   = vld_q[lk_idx];
  assign lk_tag_out = tag_q[lk_idx];
  assign lk_block   = dat_q[lk_idx];
  assign lk_hit     = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (ld_en) vld_q[lk_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      tag_q[lk_idx] <= ld_tag;
      dat_q[lk_idx] <= ld_block;
    end else if (wr_en) begin
      dat_q[lk_idx][int'(wr_off)*DATA_W +: DATA_W] <= wr_data;
    end
  end

  // R8: a word store only targets an entry that currently holds the block
  p_store_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> lk_hit);
  // R4: an installed entry is valid in the next cycle
  p_load_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> lk_valid || !$stable(lk_idx));
endmodule

// File: rtl/cvb_victim_fifo.sv
module cvb_victim_fifo #(
  parameter int VN    = 2,
  parameter int BA_W  = 9,
  parameter int BLK_W = 64,
  localparam int SLOT_W = (VN > 1) ? $clog2(VN) : 1,
  localparam int CNT_W  = $clog2(VN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BA_W-1:0]   lk_ba,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [BLK_W-1:0]  lk_block,
  input  logic              rm_en,
  input  logic [SLOT_W-1:0] rm_slot,
  input  logic              push_en,
  input  logic [BA_W-1:0]   push_ba,
  input  logic [BLK_W-1:0]  push_block,
  output logic [CNT_W-1:0]  fill_cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BA_W-1:0]  ba_q [VN];
  logic [BA_W-1:0]  ba_n [VN];
  logic [BLK_W-1:0] blk_q [VN];
  logic [BLK_W-1:0] blk_n [VN];
  logic [VN-1:0]    hit_vec;

  // entry 0 is the oldest; entries at or above cnt_q are empty
  for (genvar g = 0; g < VN; g++) begin : g_cmp
    assign hit_vec[g] = (CNT_W'(g) < cnt_q) && (ba_q[g] == lk_ba);
  end

  assign lk_hit   = |hit_vec;
  assign fill_cnt = cnt_q;

  always_comb begin
    lk_slot  = '0;
    lk_block = '0;
    for (int i = 0; i < VN; i++) begin
      if (hit_vec[i]) begin
        lk_slot  = SLOT_W'(i);
        lk_block = blk_q[i];
      end
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    for (int i = 0; i < VN; i++) begin
      ba_n[i]  = ba_q[i];
      blk_n[i] = blk_q[i];
    end
    if (rm_en) begin
      for (int i = 0; i < VN - 1; i++) begin
        if (i >= int'(rm_slot)) begin
          ba_n[i]  = ba_n[i+1];
          blk_n[i] = blk_n[i+1];
        end
      end
      cnt_n = cnt_n - 1'b1;
    end
    if (push_en) begin
      if (int'(cnt_n) == VN) begin
        for (int i = 0; i < VN - 1; i++) begin
          ba_n[i]  = ba_n[i+1];
          blk_n[i] = blk_n[i+1];
        end
        ba_n[VN-1]  = push_ba;
        blk_n[VN-1] = push_block;
      end else begin
        for (int i = 0; i < VN; i++) begin
          if (i == int'(cnt_n)) begin
            ba_n[i]  = push_ba;
            blk_n[i] = push_block;
          end
        end
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (rm_en || push_en) begin
      for (int i = 0; i < VN; i++) begin
        ba_q[i]  <= ba_n[i];
        blk_q[i] <= blk_n[i];
      end
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= VN);
  // R6: no block address held twice
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_remove_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |-> lk_hit);
  // R7: an append into a full buffer drops one entry, keeping it full
  p_full_stays_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !rm_en && int'(cnt_q) == VN) |=> int'(cnt_q) == VN);
endmodule

// File: rtl/cvb_cache.sv
module cvb_cache
  import cvb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 2,
  parameter int SETS   = 4,
  parameter int VICT   = 2,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int BA_W   = ADDR_W - OFF_W,
  localparam int TAG_W  = BA_W - IDX_W,
  localparam int BLK_W  = WORDS * DATA_W,
  localparam int SLOT_W = (VICT > 1) ? $clog2(VICT) : 1,
  localparam int CNT_W  = $clog2(VICT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BLK_W-1:0]  mem_rsp_block
);
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic [BA_W-1:0]  req_ba;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;

  assign req_ba  = cpu_addr[ADDR_W-1:OFF_W];
  assign req_idx = req_ba[IDX_W-1:0];
  assign req_tag = req_ba[BA_W-1:IDX_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  logic              m_hit, m_valid, m_ld_en, m_wr_en;
  logic [TAG_W-1:0]  m_tag;
  logic [BLK_W-1:0]  m_block, m_ld_block;
  logic              v_hit, v_rm, v_push;
  logic [SLOT_W-1:0] v_slot;
  logic [BLK_W-1:0]  v_block;
  logic [CNT_W-1:0]  v_count;

  cvb_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_main (
    .clk(clk), .rst_n(rst_core_n),
    .lk_idx(req_idx), .lk_tag(req_tag),
    .lk_hit(m_hit), .lk_valid(m_valid), .lk_tag_out(m_tag), .lk_block(m_block),
    .ld_en(m_ld_en), .ld_tag(req_tag), .ld_block(m_ld_block),
    .wr_en(m_wr_en), .wr_off(req_off), .wr_data(cpu_wdata)
  );

  cvb_victim_fifo #(.VN(VICT), .BA_W(BA_W), .BLK_W(BLK_W)) u_vict (
    .clk(clk), .rst_n(rst_core_n),
    .lk_ba(req_ba), .lk_hit(v_hit), .lk_slot(v_slot), .lk_block(v_block),
    .rm_en(v_rm), .rm_slot(v_slot),
    .push_en(v_push), .push_ba({m_tag, req_idx}), .push_block(m_block),
    .fill_cnt(v_count)
  );

  cvb_state_e st_q, st_n;
  logic       missed_q, missed_n;

  always_comb begin
    st_n          = st_q;
    missed_n      = missed_q;
    cpu_ready     = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = {req_ba, {OFF_W{1'b0}}};
    m_ld_en       = 1'b0;
    m_ld_block    = v_block;
    m_wr_en       = 1'b0;
    v_rm          = 1'b0;
    v_push        = 1'b0;
    case (st_q)
      ST_LOOK: if (cpu_valid) begin
        if (m_hit && !cpu_we) begin
          cpu_ready = 1'b1;
          missed_n  = 1'b0;
        end else if (m_hit || (!v_hit && cpu_we)) begin
          st_n = ST_WRITE;
        end else if (v_hit) begin
          st_n = ST_SWAP;
        end else begin
          st_n     = ST_FREQ;
          missed_n = 1'b1;
        end
      end
      ST_SWAP: begin
        m_ld_en = 1'b1;
        v_rm    = 1'b1;
        v_push  = m_valid;
        st_n    = ST_LOOK;
      end
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_n = ST_FWAIT;
      end
      ST_FWAIT: if (mem_rsp_valid) begin
        m_ld_en    = 1'b1;
        m_ld_block = mem_rsp_block;
        v_push     = m_valid;
        st_n       = ST_LOOK;
      end
      ST_WRITE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = cpu_addr;
        if (mem_req_ready) begin
          cpu_ready = 1'b1;
          m_wr_en   = m_hit;
          missed_n  = 1'b0;
          st_n      = ST_LOOK;
        end
      end
      default: st_n = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q     <= ST_LOOK;
      missed_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      missed_q <= missed_n;
    end
  end

  assign cpu_hit       = cpu_ready && m_hit && !missed_q;
  assign cpu_rdata     = m_block[int'(req_off)*DATA_W +: DATA_W];
  assign mem_req_wdata = cpu_wdata;

  // R6: the two structures never both claim the requested block
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpu_valid && st_q == ST_LOOK) |-> !(m_hit && v_hit));
  p_swap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_SWAP) |-> (!cpu_ready && !mem_req_valid && v_hit));
  // R5: requester holds the address, so the swapped block hits next cycle
  p_swap_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_SWAP) |=> m_hit);
  p_read_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_LOOK && cpu_valid && !cpu_we && m_hit) |-> (cpu_ready && !mem_req_valid));
  // R4: a fill that displaces a valid block leaves the victim buffer non-empty
  p_fill_pushes_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_FWAIT && mem_rsp_valid && m_valid) |=> (v_count != '0));
endmodule

// File: tb/sim_cvb_cache.sv
`timescale 1ns/1ps
module sim_cvb_cache;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int VN     = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_valid, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_ready, cpu_hit;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req_valid, mem_req_ready, mem_req_we;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_block;

  always #2.5 clk = ~clk;

  cvb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(2), .SETS(4), .VICT(VN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_block(mem_rsp_block)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference: backing memory, main tags, victim age queue
  int mem [1024];
  bit mv  [4];
  int mba [4];
  int vq  [$];

  int req_cnt = 0;
  bit last_we;
  int last_addr, last_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory responder: observes at negedge, answers fills two cycles later
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_block = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        last_we    = mem_req_we;
        last_addr  = int'(mem_req_addr);
        last_wdata = int'(mem_req_wdata);
        if (!mem_req_we) begin
          repeat (2) @(negedge clk);
          mem_rsp_block = {32'(mem[last_addr + 1]), 32'(mem[last_addr])};
          mem_rsp_valid = 1'b1;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  task automatic access(input bit we, input int addr, input int wdata, input string req);
    int  ba, idx, vpos, lat, reqs0, k, exp_maddr;
    bit  mh, exp_hit, exp_mem;
    ba   = addr >> 1;
    idx  = ba & 3;
    mh   = mv[idx] && (mba[idx] == ba);
    vpos = -1;
    foreach (vq[i]) if (vq[i] == ba) vpos = i;
    if (mh) begin
      exp_hit = 1; lat = we ? 1 : 0;
    end else if (vpos >= 0) begin
      exp_hit = 1; lat = we ? 3 : 2;
      vq.delete(vpos);
      if (mv[idx]) vq.push_back(mba[idx]);
      mv[idx] = 1; mba[idx] = ba;
    end else if (we) begin
      exp_hit = 0; lat = 1;
    end else begin
      exp_hit = 0; lat = -1;
      if (mv[idx]) begin
        if (vq.size() == VN) void'(vq.pop_front());
        vq.push_back(mba[idx]);
      end
      mv[idx] = 1; mba[idx] = ba;
    end
    exp_mem   = we || (lat < 0);
    exp_maddr = we ? addr : (addr & ~1);
    if (we) mem[addr] = wdata;
    reqs0 = req_cnt;
    cpu_valid = 1'b1;
    cpu_we    = we;
    cpu_addr  = ADDR_W'(addr);
    cpu_wdata = DATA_W'(wdata);
    k = 0;
    forever begin
      #1;
      if (cpu_ready || k >= 60) break;
      @(negedge clk);
      k++;
    end
    check(cpu_ready == 1'b1, req, "ready", cpu_ready, 1);
    if (lat >= 0) check(k == lat, req, "latency", k, lat);
    check(cpu_hit == exp_hit, req, "hit", cpu_hit, exp_hit);
    if (!we) check(cpu_rdata == DATA_W'(mem[addr]), req, "rdata", cpu_rdata, DATA_W'(mem[addr]));
    check((req_cnt - reqs0) == (exp_mem ? 1 : 0), req, "mem requests", req_cnt - reqs0, exp_mem ? 1 : 0);
    if (exp_mem) begin
      check(last_we == we, req, "mem we", last_we, we);
      check(last_addr == exp_maddr, req, "mem addr", last_addr, exp_maddr);
      if (we) check(last_wdata == wdata, req, "mem wdata", last_wdata, wdata);
    end
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 1024; i++) mem[i] = i * 7919 + 32'h1234_0000;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mba[i] = 0; end
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b0, "R1", "ready in reset", cpu_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_ready == 1'b0, "R1", "ready idle", cpu_ready, 0);
    check(mem_req_valid == 1'b0, "R1", "mem idle", mem_req_valid, 0);

    // A=0x000 B=0x008 C=0x010 D=0x018 share index 0
    access(0, 'h000, 0, "R1");   // first read misses
    access(0, 'h001, 0, "R2");   // same block, other word
    access(0, 'h002, 0, "R3");   // index 1 fill
    access(0, 'h000, 0, "R11");  // index 0 still present
    access(0, 'h008, 0, "R4");   // B evicts A into victim
    access(0, 'h000, 0, "R5");   // victim hit, swap
    access(0, 'h009, 0, "R6");   // B found in victim again
    access(0, 'h010, 0, "R4");   // C: victim now [A,B]
    access(0, 'h001, 0, "R7");   // A hit: victim [B,C]
    access(0, 'h018, 0, "R7");   // D: B dropped, victim [C,A]
    access(0, 'h008, 0, "R7");   // B misses
    access(0, 'h000, 0, "R7");   // A still held
    access(1, 'h000, 32'h0BAD_F00D, "R8");
    access(0, 'h000, 0, "R8");
    access(1, 'h030, 32'h1357_2468, "R9");
    access(0, 'h030, 0, "R9");   // not allocated: misses
    access(1, 'h001, 32'h7777_1111, "R10");
    access(0, 'h001, 0, "R10");

    seed = 32'h1F2E_3D4C;
    for (int n = 0; n < 300; n++) begin
      int a, w;
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 8) & 63;
      w = (((seed >>> 20) & 3) == 0) ? 1 : 0;
      access(w[0], a, seed ^ 32'h5A5A_A5A5, "R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule